// File: doc/BRIEF.md
# Serial Autobaud Calibration and Handshake

This block listens on an asynchronous serial receive line after reset and works out the host's bit rate without being told. The host sends a byte of value zero in 8N1 framing. The start bit and the eight zero data bits make one unbroken low stretch that is nine bit-times long. The block counts the system-clock cycles of that stretch and divides the count by nine, rounding to the nearest whole number. The result is the bit-period divisor, which is presented on an output for the logic that runs after calibration.

Once the line has been high for one derived bit-time, the block checks that the divisor matches a supported host rate for its clock. If it does, the block sends one zero byte at the derived rate to tell the host that calibration is done. It then receives one byte from the host. A reply of 0x55 with a valid stop bit sets `locked`. Any other outcome sets `error`. Both results hold until the next reset, so a failed attempt is retried only by resetting.

Top module: `autobaud_lock`

## Requirements
- R1: After reset, `txd` is high, `locked` and `error` are low and `divisor` is zero.
- R2: For a first low stretch of L clock cycles on `rxd`, `divisor` becomes floor((L + 4) / 9), so a fraction of one half or more rounds up.
- R3: After the line has been high for one bit-time, exactly one frame is sent on `txd`: a low stretch of exactly 9 x `divisor` cycles (start bit plus byte 0x00), followed by a high stop bit and idle.
- R4: A reply of 0x55 with a high stop bit sets `locked`, and `error` stays low.
- R5: A reply other than 0x55 sets `error` and leaves `locked` low.
- R6: A reply whose stop bit is sampled low sets `error`, even when its data bits equal 0x55.
- R7: The divisor is accepted only if it lies within ±TOL_PCT percent of CLK_HZ/9600 while CLK_HZ is between 8 and 18 MHz, or within ±TOL_PCT percent of CLK_HZ/4800 while CLK_HZ is between 4 and 18 MHz. Any other divisor sets `error` and nothing is sent on `txd`.
- R8: If the low stretch lasts longer than the count for a rate below 4800 bit/s at 18 MHz (with the tolerance added), `error` is set while the line is still low.
- R9: If the line falls again before one full bit-time of high has passed after the low stretch, `error` is set and nothing is sent.
- R10: `locked` and `error` are never high together. Each stays high until reset, and `divisor` does not change while `locked` is high.
- R11: Reply bits are received least significant bit first and sampled at the middle of each bit period, so the bit-reversed byte 0xAA is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial receive line from the host, idle high |
| txd | output | 1 | Serial transmit line to the host, idle high |
| divisor | output | CNT_W (16 by default) | Derived bit period in clock cycles |
| locked | output | 1 | Calibration confirmed by the host |
| error | output | 1 | Calibration failed; reset is needed to retry |

## Verification
The bench uses two clock settings, 8 MHz and 4 MHz, and feeds in low stretches that are exact multiples of nine as well as stretches sitting on either side of the rounding point. A divider that truncates instead of rounding gives a divisor one too small. The 9600 bit/s case on the 4 MHz instance falls inside the numeric window but outside the allowed clock range, and a design that checks only the window would send an acknowledge there. The bit-reversed reply 0xAA and a 0x55 reply with a low stop bit catch a receiver that shifts in the wrong order or ignores framing. A stuck-low line and a high gap that is too short catch a design that keeps waiting or sends the acknowledge too early.

// File: rtl/abd_pkg.sv
// Package: shared constants, state encodings and the rounding divide used
// by the autobaud calibration block. Assumes 8N1 framing throughout.
package abd_pkg;

    localparam int FAST_BAUD    = 9600;
    localparam int SLOW_BAUD    = 4800;
    localparam int FAST_CLK_MIN = 8_000_000;
    localparam int SLOW_CLK_MIN = 4_000_000;
    localparam int CLK_CEILING  = 18_000_000;
    localparam int RUN_BITS     = 9;     // start bit plus eight zero data bits
    localparam int FRAME_LEN    = 10;    // start + 8 data + 1 stop
    localparam logic [7:0] ACK_BYTE   = 8'h00;
    localparam logic [7:0] REPLY_BYTE = 8'h55;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_ACK,
        ST_REPLY,
        ST_LOCKED,
        ST_FAIL
    } cal_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_phase_e;

    // Rounded division of a cycle count by the run length in bits.
    function automatic logic [31:0] div9_round(input logic [31:0] x);
        return (x + 32'(RUN_BITS / 2)) / 32'(RUN_BITS);
    endfunction

endpackage

// File: rtl/abd_sync.sv
// Module: two-flop synchronizer for the asynchronous receive line, plus
// one extra stage that gives single-cycle fall and rise pulses.
// Assumes the line idles high, so every stage resets to one.
module abd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    // Shift the raw line through the synchronizer and the edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line_s = sync_q;
    assign fall   = prev_q & ~sync_q;
    assign rise   = ~prev_q & sync_q;
endmodule

// File: rtl/abd_uart_tx.sv
// Module: single-byte 8N1 transmitter with a run-time bit divisor.
// Each bit is held for exactly `div` clock cycles. A start request is
// accepted only while idle. `done` pulses once after the stop bit.
module abd_uart_tx
    import abd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] div,
    input  logic [7:0]   data,
    output logic         txd,
    output logic         done
);
    localparam int BIT_W = $clog2(FRAME_LEN);

    logic [FRAME_LEN-1:0] frame_q;
    logic [BIT_W-1:0]     bit_q;
    logic [W-1:0]         cnt_q;
    logic                 busy_q;
    logic                 done_q;

    // Load the frame on start, then shift one bit every div cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '1;
            bit_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q  <= 1'b1;
                    frame_q <= {1'b1, data, 1'b0};
                    bit_q   <= '0;
                    cnt_q   <= W'(1);
                end
            end else if (cnt_q >= div) begin
                cnt_q   <= W'(1);
                frame_q <= {1'b1, frame_q[FRAME_LEN-1:1]};
                if (bit_q == BIT_W'(FRAME_LEN - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    bit_q <= bit_q + BIT_W'(1);
                end
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end

    assign txd  = busy_q ? frame_q[0] : 1'b1;
    assign done = done_q;
endmodule

// File: rtl/abd_uart_rx.sv
// Module: single-byte 8N1 receiver with a run-time bit divisor.
// A synchronized falling edge starts a frame. The start bit is re-checked
// at half a bit, and data and stop bits are sampled one bit-time apart
// after that, least significant bit first. Assumes div >= 2.
module abd_uart_rx
    import abd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] div,
    input  logic         line_s,
    input  logic         fall,
    output logic         done,
    output logic [7:0]   data,
    output logic         frame_err
);
    rx_phase_e    phase_q;
    logic [W-1:0] cnt_q;
    logic [2:0]   bit_q;
    logic [7:0]   shift_q;
    logic         done_q;
    logic         ferr_q;
    logic [W-1:0] half;

    assign half = div >> 1;

    // Walk through start check, data bits and stop bit for one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            done_q  <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                RX_IDLE: begin
                    if (en && fall) begin
                        phase_q <= RX_START;
                        cnt_q   <= W'(1);
                    end
                end
                RX_START: begin
                    if (cnt_q >= half) begin
                        cnt_q   <= W'(1);
                        bit_q   <= '0;
                        phase_q <= line_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + W'(1);
                    end
                end
                RX_DATA: begin
                    if (cnt_q >= div) begin
                        cnt_q   <= W'(1);
                        shift_q <= {line_s, shift_q[7:1]};
                        if (bit_q == 3'd7) begin
                            phase_q <= RX_STOP;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                        end
                    end else begin
                        cnt_q <= cnt_q + W'(1);
                    end
                end
                default: begin
                    if (cnt_q >= div) begin
                        done_q  <= 1'b1;
                        ferr_q  <= ~line_s;
                        phase_q <= RX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + W'(1);
                    end
                end
            endcase
        end
    end

    assign done      = done_q;
    assign data      = shift_q;
    assign frame_err = ferr_q;
endmodule

// File: rtl/autobaud_lock.sv
// Module: autobaud calibration. It measures the nine-bit low run of a
// 0x00 byte, derives the bit divisor, checks it against the supported
// host rates for CLK_HZ, sends a 0x00 acknowledge and waits for a 0x55
// reply. The locked and failed states hold until reset.
// Assumes one host, 8N1 framing and a line that idles high.
module autobaud_lock
    import abd_pkg::*;
#(
    parameter int CLK_HZ     = 12_000_000,
    parameter int MAX_CLK_HZ = 18_000_000,
    parameter int TOL_PCT    = 5,
    localparam int MAX_LOW   = (MAX_CLK_HZ / SLOW_BAUD) * RUN_BITS * (100 + TOL_PCT) / 100,
    localparam int CNT_W     = $clog2(MAX_LOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    output logic             txd,
    output logic [CNT_W-1:0] divisor,
    output logic             locked,
    output logic             error
);
    localparam int N_FAST = CLK_HZ / FAST_BAUD;
    localparam int N_SLOW = CLK_HZ / SLOW_BAUD;
    localparam logic [31:0] FAST_LO = 32'(N_FAST - N_FAST * TOL_PCT / 100);
    localparam logic [31:0] FAST_HI = 32'(N_FAST + N_FAST * TOL_PCT / 100);
    localparam logic [31:0] SLOW_LO = 32'(N_SLOW - N_SLOW * TOL_PCT / 100);
    localparam logic [31:0] SLOW_HI = 32'(N_SLOW + N_SLOW * TOL_PCT / 100);
    localparam bit FAST_OK = (CLK_HZ >= FAST_CLK_MIN) && (CLK_HZ <= CLK_CEILING);
    localparam bit SLOW_OK = (CLK_HZ >= SLOW_CLK_MIN) && (CLK_HZ <= CLK_CEILING);
    localparam logic [31:0] LOW_LIMIT = 32'(MAX_LOW);

    cal_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] div_q;
    logic             tx_start_q;
    logic [31:0]      cnt_ext;
    logic [31:0]      div_ext;
    logic             rate_ok;
    logic             line_s, line_fall, line_rise;
    logic             tx_done;
    logic             rx_done, rx_ferr;
    logic [7:0]       rx_data;

    abd_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (rxd),
        .line_s  (line_s),
        .fall    (line_fall),
        .rise    (line_rise)
    );

    abd_uart_tx #(.W(CNT_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start_q),
        .div   (div_q),
        .data  (ACK_BYTE),
        .txd   (txd),
        .done  (tx_done)
    );

    abd_uart_rx #(.W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (state_q == ST_REPLY),
        .div       (div_q),
        .line_s    (line_s),
        .fall      (line_fall),
        .done      (rx_done),
        .data      (rx_data),
        .frame_err (rx_ferr)
    );

    assign cnt_ext = 32'(cnt_q);
    assign div_ext = 32'(div_q);

    // Accept the divisor only inside a window whose rate suits this clock.
    always_comb begin
        rate_ok = (FAST_OK && div_ext >= FAST_LO && div_ext <= FAST_HI) ||
                  (SLOW_OK && div_ext >= SLOW_LO && div_ext <= SLOW_HI);
    end

    // Calibration sequence: measure, settle, acknowledge, confirm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            div_q      <= '0;
            tx_start_q <= 1'b0;
        end else begin
            tx_start_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (line_fall) begin
                        state_q <= ST_LOW;
                        cnt_q   <= CNT_W'(1);
                    end
                end
                ST_LOW: begin
                    if (!line_s) begin
                        if (cnt_ext >= LOW_LIMIT) begin
                            state_q <= ST_FAIL;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end else begin
                        div_q   <= CNT_W'(div9_round(cnt_ext));
                        cnt_q   <= CNT_W'(1);
                        state_q <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (!line_s) begin
                        state_q <= ST_FAIL;
                    end else if (cnt_q >= div_q) begin
                        if (rate_ok) begin
                            state_q    <= ST_ACK;
                            tx_start_q <= 1'b1;
                        end else begin
                            state_q <= ST_FAIL;
                        end
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_ACK: begin
                    if (tx_done) begin
                        state_q <= ST_REPLY;
                    end
                end
                ST_REPLY: begin
                    if (rx_done) begin
                        state_q <= (rx_ferr || rx_data != REPLY_BYTE) ? ST_FAIL : ST_LOCKED;
                    end
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end

    assign divisor = div_q;
    assign locked  = (state_q == ST_LOCKED);
    assign error   = (state_q == ST_FAIL);

    logic unused_rise;
    assign unused_rise = line_rise;
endmodule

// File: rtl/autobaud_lock_chk.sv
// Module: property checker for autobaud_lock, bound to every instance.
// It observes only the top-level ports.
module autobaud_lock_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         txd,
    input logic [W-1:0] divisor,
    input logic         locked,
    input logic         error
);
    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && error));

    assert_locked_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_error_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    assert_div_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(divisor));

    assert_quiet_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> txd);

    assert_quiet_on_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> txd);

    assert_nonzero_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (divisor != '0));
endmodule

bind autobaud_lock autobaud_lock_chk #(.W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .txd     (txd),
    .divisor (divisor),
    .locked  (locked),
    .error   (error)
);

// File: tb/tb_autobaud_lock.sv
// Bench: two instances, at 8 MHz and 4 MHz, driven through calibration,
// acknowledge and reply scenarios. Expected divisors and run lengths are
// computed from the bit periods the bench applies.
module tb_autobaud_lock;
    localparam int W       = 16;
    localparam int MAX_LOW = (18_000_000 / 4800) * 9 * 105 / 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd_a = 1'b1;
    logic rxd_b = 1'b1;
    logic txd_a, txd_b, lock_a, lock_b, err_a, err_b;
    logic [W-1:0] div_a, div_b;

    int vectors = 0;
    int miscompares = 0;
    bit mon_clr = 1'b0;
    int mon_a = 0;
    int mon_b = 0;

    autobaud_lock #(.CLK_HZ(8_000_000)) dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd_a), .txd(txd_a),
        .divisor(div_a), .locked(lock_a), .error(err_a)
    );

    autobaud_lock #(.CLK_HZ(4_000_000)) dut_lo (
        .clk(clk), .rst_n(rst_n), .rxd(rxd_b), .txd(txd_b),
        .divisor(div_b), .locked(lock_b), .error(err_b)
    );

    always #4 clk = ~clk;

    // Count the cycles in which each transmit line is low.
    always @(negedge clk) begin
        if (mon_clr) begin
            mon_a = 0;
            mon_b = 0;
        end else begin
            if (!txd_a) mon_a = mon_a + 1;
            if (!txd_b) mon_b = mon_b + 1;
        end
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input bit sel, input logic v);
        if (sel) rxd_b = v;
        else     rxd_a = v;
    endtask

    function automatic logic txd_of(input bit sel);
        return sel ? txd_b : txd_a;
    endfunction

    function automatic int div_of(input bit sel);
        return sel ? int'(div_b) : int'(div_a);
    endfunction

    function automatic int lock_of(input bit sel);
        return sel ? int'(lock_b) : int'(lock_a);
    endfunction

    function automatic int err_of(input bit sel);
        return sel ? int'(err_b) : int'(err_a);
    endfunction

    function automatic int mon_of(input bit sel);
        return sel ? mon_b : mon_a;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        rxd_a = 1'b1;
        rxd_b = 1'b1;
        mon_clr = 1'b1;
        idle(5);
        rst_n = 1'b1;
        mon_clr = 1'b0;
        idle(5);
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        idle(1);
        mon_clr = 1'b0;
    endtask

    task automatic low_run(input bit sel, input int len);
        drive(sel, 1'b0);
        idle(len);
        drive(sel, 1'b1);
    endtask

    task automatic send_frame(input bit sel, input logic [7:0] d, input int bp, input logic stopv);
        drive(sel, 1'b0);
        idle(bp);
        for (int i = 0; i < 8; i++) begin
            drive(sel, d[i]);
            idle(bp);
        end
        drive(sel, stopv);
        idle(bp);
        drive(sel, 1'b1);
    endtask

    task automatic wait_ack(input bit sel, input int bp, output int lowlen);
        int t = 0;
        while (txd_of(sel) && t < 4 * bp) begin
            idle(1);
            t++;
        end
        lowlen = 0;
        while (!txd_of(sel) && lowlen < 20 * bp) begin
            idle(1);
            lowlen++;
        end
    endtask

    // Run a full calibration up to the reply on one instance.
    task automatic calibrate_and_ack(input bit sel, input int bp, input string req);
        int len;
        low_run(sel, 9 * bp);
        wait_ack(sel, bp, len);
        check({req, " ack low run"}, len, 9 * bp);
        check({req, " divisor"}, div_of(sel), bp);
        idle(2 * bp);
    endtask

    initial begin
        repeat (199_000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        do_reset();

        // R1: reset state on both instances
        check("R1 txd a", int'(txd_a), 1);
        check("R1 locked a", int'(lock_a), 0);
        check("R1 error a", int'(err_a), 0);
        check("R1 divisor a", int'(div_a), 0);
        check("R1 txd b", int'(txd_b), 1);
        check("R1 locked b", int'(lock_b), 0);
        check("R1 error b", int'(err_b), 0);
        check("R1 divisor b", int'(div_b), 0);

        // R3 R4: 9600 bit/s at 8 MHz, good reply
        begin
            int len;
            low_run(0, 9 * 833);
            wait_ack(0, 833, len);
            check("R3 ack low run 9600", len, 9 * 833);
            check("R2 divisor 9600", div_a, 833);
            clear_mon();
            idle(2 * 833);
            check("R3 single ack frame", mon_a, 0);
            send_frame(0, 8'h55, 833, 1'b1);
            idle(10);
            check("R4 locked", int'(lock_a), 1);
            check("R4 no error", int'(err_a), 0);
            idle(200);
            check("R10 lock held", int'(lock_a), 1);
            check("R10 divisor held", div_a, 833);
        end

        // R5 R11: bit-reversed reply rejected
        do_reset();
        calibrate_and_ack(0, 833, "R11");
        send_frame(0, 8'hAA, 833, 1'b1);
        idle(10);
        check("R5 R11 error on 0xAA", int'(err_a), 1);
        check("R5 R11 no lock on 0xAA", int'(lock_a), 0);

        // R6: correct data with a low stop bit
        do_reset();
        calibrate_and_ack(0, 833, "R6");
        send_frame(0, 8'h55, 833, 1'b0);
        idle(10);
        check("R6 framing error", int'(err_a), 1);
        check("R6 no lock", int'(lock_a), 0);

        // R7: 19200 bit/s at 8 MHz is outside both windows
        do_reset();
        clear_mon();
        low_run(0, 9 * 417);
        idle(3 * 417);
        check("R7 reject 19200 error", int'(err_a), 1);
        check("R7 reject 19200 no ack", mon_a, 0);
        check("R2 divisor 19200", div_a, 417);

        // R9: line falls again before one bit-time of high
        do_reset();
        clear_mon();
        low_run(0, 9 * 833);
        idle(300);
        low_run(0, 50);
        idle(10);
        check("R9 short high error", int'(err_a), 1);
        check("R9 short high no ack", mon_a, 0);

        // R2: rounding on both sides of one half
        do_reset();
        low_run(0, 9 * 417 + 4);
        idle(6);
        check("R2 round down", div_a, 417);
        do_reset();
        low_run(0, 9 * 417 + 5);
        idle(6);
        check("R2 round up", div_a, 418);

        // R7: 4800 bit/s at 4 MHz accepted and locked
        do_reset();
        calibrate_and_ack(1, 833, "R7 4800");
        send_frame(1, 8'h55, 833, 1'b1);
        idle(10);
        check("R7 4800 locked", lock_of(1), 1);
        check("R7 4800 no error", err_of(1), 0);

        // R7: 9600 bit/s at 4 MHz, clock below the 8 MHz floor
        do_reset();
        clear_mon();
        low_run(1, 9 * 417);
        idle(3 * 417);
        check("R7 9600 at 4MHz error", err_of(1), 1);
        check("R7 9600 at 4MHz no ack", mon_of(1), 0);

        // R8: stuck-low line aborts while still low
        do_reset();
        drive(1, 1'b0);
        idle(MAX_LOW + 50);
        check("R8 abort while low", err_of(1), 1);
        check("R8 no lock", lock_of(1), 0);
        drive(1, 1'b1);
        idle(5);

        report();
        $finish;
    end
endmodule